// File: doc/BRIEF.md
# One-Wire Slot Clock Divider

This block derives the slow timing tick used by a one-wire bus master from whatever system clock the chip provides. A host writes one divisor byte. The byte carries an enable flag, an odd prescale selector and a power-of-two exponent. The block then produces a one-cycle-wide `tick` enable whose period is the product of the two factors, counted in system clock cycles. The host picks the byte so that the tick lands near 1 MHz. Some examples: 0x80 for a 1 MHz input, 0x81 for 3 MHz, 0x85 for 6 MHz, 0x8C for 8 MHz and 0x9C for 128 MHz.

Two cascaded counters do the division. The first is a prescaler that wraps every 1, 3, 5 or 7 cycles. The second advances once per prescaler wrap and wraps after 2^k wraps. The tick fires on the cycle in which both counters sit at their terminal values. Every write to the divisor clears both counters, so the new ratio takes effect from a known phase. The host still waits about a millisecond after a write before it starts bus traffic.

Top module: `owt_clkdiv`

## Requirements
- R1: After reset the divisor register holds 0x00 and `tick` is low.
- R2: While divisor bit 7 is 0, `tick` stays low and both counters are held at zero. A later enabling write therefore starts from a zero phase.
- R3: Divisor bits [1:0] select the prescale: code 0 gives 1, code 1 gives 3, code 2 gives 5 and code 3 gives 7.
- R4: Divisor bits [4:2] hold an exponent k, which adds a further divide by 2^k (1 to 128).
- R5: With bit 7 set, the tick period is the prescale multiplied by 2^k, in system clock cycles.
- R6: Whenever the ratio is above 1, `tick` is high for exactly one clock cycle in each period.
- R7: A write to the divisor restarts both counters. The first tick appears in the (ratio-1)-th cycle after the write edge, where cycle 0 is the cycle that follows that edge. This holds even when the write lands in the middle of a period.
- R8: Divisor bits [6:5] have no effect on the tick pattern.
- R9: With ratio 1 (0x80), `tick` is high in every cycle from the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divWrEn | input | 1 | Divisor write strobe, one cycle |
| divWrData | input | 8 | Divisor byte to write |
| tick | output | 1 | One-cycle tick enable |

## Verification
The assertions take for granted that `divWrEn` is a clean strobe sampled at the clock edge. They also assume that a write in the same cycle as a terminal count may legally cut the period short, so the one-cycle-width property is not checked across a write. The stimulus asserts `divWrEn` for exactly one cycle, drives it only at falling edges, and then lets each setting run long enough to cover two full periods.

// File: rtl/owt_pkg.sv
package owt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // zero both counters this cycle
    logic run;     // divider enabled
  } owtStrobe_t;
endpackage

// File: rtl/owt_ctrl.sv
module owt_ctrl
  import owt_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  output owtStrobe_t       strobe,
  output logic [SEL_W-1:0] preSel,
  output logic [EXP_W-1:0] expSel
);
  localparam int EN_BIT = DIV_W - 1;
  localparam int EXP_LO = SEL_W;
  localparam int EXP_HI = SEL_W + EXP_W - 1;

  logic [DIV_W-1:0] divReg;

  always_ff @(posedge clk) begin
    if (!rst_n)       divReg <= '0;
    else if (divWrEn) divReg <= divWrData;
  end

  always_comb begin
    strobe.run   = divReg[EN_BIT];
    strobe.clear = divWrEn || !divReg[EN_BIT];
    preSel       = divReg[SEL_W-1:0];
    expSel       = divReg[EXP_HI:EXP_LO];
  end

  // R7: a write lands in the register on the next edge
  assert_write_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    divWrEn |=> divReg == $past(divWrData));
  // R1: the register comes out of reset disabled
  assert_reset_disabled_R1: assert property (@(posedge clk)
    $past(!rst_n) && rst_n |-> !divReg[EN_BIT]);
endmodule

// File: rtl/owt_datapath.sv
module owt_datapath
  import owt_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  owtStrobe_t       strobe,
  input  logic [SEL_W-1:0] preSel,
  input  logic [EXP_W-1:0] expSel,
  output logic             tick
);
  localparam int PRE_W = SEL_W + 1;
  localparam int POW_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] preCnt, preMax;
  logic [POW_W-1:0] powCnt, powMax;
  logic preAtMax, powAtMax;

  // prescale 2*code+1 -> terminal count 2*code
  assign preMax = {preSel, 1'b0};

  // thermometer mask: 2^k - 1
  for (genvar i = 0; i < POW_W; i++) begin : g_powMask
    assign powMax[i] = (EXP_W'(i) < expSel);
  end

  assign preAtMax = (preCnt == preMax);
  assign powAtMax = (powCnt == powMax);

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      preCnt <= '0;
      powCnt <= '0;
    end else if (preAtMax) begin
      preCnt <= '0;
      powCnt <= powAtMax ? '0 : powCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign tick = strobe.run && preAtMax && powAtMax;

  // R2: a clear leaves both counters at zero
  assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (preCnt == '0) && (powCnt == '0));
  // R3: prescaler never passes its terminal count
  assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt <= preMax);
  // R4: second stage advances only on a prescaler wrap
  assert_pow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.clear && !preAtMax) |=> $stable(powCnt));
  // R6: tick is a single-cycle pulse when the ratio exceeds one
  assert_tick_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !strobe.clear && ((preMax != '0) || (powMax != '0))) |=> !tick);
endmodule

// File: rtl/owt_clkdiv.sv
module owt_clkdiv
  import owt_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int EXP_W = 3,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  output logic             tick
);
  owtStrobe_t       strobe;
  logic [SEL_W-1:0] preSel;
  logic [EXP_W-1:0] expSel;

  owt_ctrl #(.DIV_W(DIV_W), .SEL_W(SEL_W), .EXP_W(EXP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .divWrEn(divWrEn), .divWrData(divWrData),
    .strobe(strobe), .preSel(preSel), .expSel(expSel));

  owt_datapath #(.SEL_W(SEL_W), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .preSel(preSel),
    .expSel(expSel), .tick(tick));

  // R2: no tick in the cycle after reset
  assert_idle_after_reset_R2: assert property (@(posedge clk)
    $past(!rst_n) && rst_n && !divWrEn |-> !tick);
endmodule

// File: tb/owt_clkdiv_bench.sv
module owt_clkdiv_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic divWrEn = 1'b0;
  logic [7:0] divWrData = '0;
  logic tick;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owt_clkdiv u_owt_clkdiv (.clk(clk), .rst_n(rst_n), .divWrEn(divWrEn),
                           .divWrData(divWrData), .tick(tick));

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // write a byte; returns at the negedge of cycle 0 after the write edge
  task automatic writeDiv(input logic [7:0] v);
    @(negedge clk);
    divWrEn = 1'b1;
    divWrData = v;
    @(negedge clk);
    divWrEn = 1'b0;
  endtask

  // observe len cycles from cycle 0; tick expected where i % ratio == ratio-1
  task automatic runPattern(input string req, input logic [7:0] v, input int ratio, input int len);
    int bad = 0, firstBad = -1, cnt = 0;
    writeDiv(v);
    for (int i = 0; i < len; i++) begin
      logic expT;
      if (i > 0) @(negedge clk);
      expT = (ratio > 0) && ((i % ratio) == ratio - 1);
      if (tick) cnt++;
      if (tick != expT) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    end
    check(req, bad, 0, $sformatf("mismatched cycles for 0x%02h (first at %0d)", v, firstBad));
    check(req, cnt, (ratio > 0) ? len / ratio : 0, $sformatf("tick count for 0x%02h", v));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", tick, 0, "tick during reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", tick, 0, "tick after reset");
  endtask

  task automatic testPrescale();  // R3
    runPattern("R3", 8'h81, 3, 30);
    runPattern("R3", 8'h82, 5, 30);
    runPattern("R3", 8'h83, 7, 35);
  endtask

  task automatic testExponent();  // R4, R5
    runPattern("R4", 8'h84, 2, 20);
    runPattern("R4", 8'h8C, 8, 32);
    runPattern("R4", 8'h9C, 128, 256);
    runPattern("R5", 8'h85, 6, 36);
    runPattern("R5", 8'h9F, 896, 1792);
  endtask

  task automatic testUnity();  // R9
    runPattern("R9", 8'h80, 1, 20);
  endtask

  task automatic testDisabled();  // R2
    runPattern("R2", 8'h0D, 0, 200);
    runPattern("R2", 8'h83, 7, 21);  // enabling write starts from zero phase
  endtask

  task automatic testRestart();  // R7, R6
    writeDiv(8'h83);
    repeat (3) @(negedge clk);
    runPattern("R7", 8'h83, 7, 28);
    writeDiv(8'h8C);
    repeat (4) @(negedge clk);
    runPattern("R6", 8'h81, 3, 30);
  endtask

  task automatic testIgnoredBits();  // R8
    runPattern("R8", 8'hE5, 6, 36);
    runPattern("R8", 8'hA2, 5, 25);
  endtask

  initial begin
    testReset();
    testPrescale();
    testExponent();
    testUnity();
    testDisabled();
    testRestart();
    testIgnoredBits();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule